// File: doc/BRIEF.md
# Converter Channel Power-Up Sequencer

This block governs when one audio converter channel is allowed to deliver data. An active-low power-down input acts as the global reset: while it is low, every register in the block returns to its default, the channel reports not-ready and its serial data output is driven low. When power-down is released, the block waits until a master clock is seen toggling. It then starts an initialization phase on the next rising edge of the frame clock. The phase lasts a fixed number of frame periods. Only after that does the channel reach its run state, where converter serial data is passed to the output.

A one-bit channel power-enable register, written through a strobe, can stop the channel without touching any other state. Clearing it sends the block back to waiting for clocks. Setting it again starts a new initialization with the full count. The master clock is watched by a timeout counter in the system clock domain. If the master clock stops, the block drops back to power-down. Each new initialization is announced by a one-cycle filter-reset pulse. The length of the initialization is chosen by a side parameter: 522 frame periods for the capture (ADC) side and 516 for the playback (DAC) side.

Top module: `codec_pwrup_seq`

## Requirements
- R1: While `pdn_n` is low, `ready_o`, `sdto_o` and `filt_rst_o` are 0 and the power-enable register returns to its default of 1, so that after release no write is needed before initialization can start.
- R2: `sdto_o` is 0 whenever `ready_o` is 0. While `ready_o` is 1, `sdto_o` equals `sdti_i`.
- R3: Initialization starts only on a synchronized rising edge of `lrck_i` that arrives while the master clock is present and the power-enable bit is 1. Frame edges seen without a master clock start nothing.
- R4: `ready_o` rises only on a frame rising edge. That edge is the INIT_FRAMES-th rising edge after the one that started initialization, with INIT_FRAMES = 522 for SIDE = ADC (the default) and 516 for SIDE = DAC. During initialization `sdto_o` stays 0.
- R5: Each start of initialization produces exactly one `filt_rst_o` pulse, which is one system clock long.
- R6: The master clock counts as lost when no edge of `mclk_i` has been seen for MCLK_TIMEOUT (64) system clocks. Loss during initialization or run returns the block to power-down and clears `ready_o`.
- R7: Writing 0 to the power-enable bit (`pwr_wr_i` high, `pwr_wdata_i` = 0) during initialization or run drops `ready_o` and `sdto_o` to 0 within a few system clocks. The block waits for clocks again, the written value is kept, and no frame edge restarts it while the bit is 0.
- R8: Writing 1 to the power-enable bit after clearing it, even in the middle of an initialization, starts a new initialization on the next frame rising edge. That initialization again lasts the full INIT_FRAMES periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pdn_n | input | 1 | Active-low power-down; asynchronous reset of all state |
| mclk_i | input | 1 | Master clock, asynchronous to clk |
| lrck_i | input | 1 | Frame clock, asynchronous to clk |
| pwr_wr_i | input | 1 | Write strobe for the channel power-enable bit |
| pwr_wdata_i | input | 1 | Value written to the power-enable bit |
| sdti_i | input | 1 | Serial data from the converter |
| sdto_o | output | 1 | Gated serial data output |
| ready_o | output | 1 | High while the channel is in the run state |
| filt_rst_o | output | 1 | One-cycle digital filter reset pulse at each initialization start |

## Verification
The assertions check on every cycle that the output is gated whenever the channel is not ready. They also check that a start or a run entry never happens without its frame edge and clock conditions, that the frame counter stays in range, that the filter pulse is one cycle long, and that clock loss and a cleared power bit each force the correct next state. Some properties cover whole sequences and only the bench scenarios can show them. These are the exact count of 522 frame periods, the restart from zero after the power bit is toggled mid-initialization, the register default coming back after a power-down pulse, and the need for a real master clock before anything starts.

// File: rtl/codec_pwrup_pkg.sv
package codec_pwrup_pkg;

    typedef enum logic [1:0] {
        ST_POWER_DOWN  = 2'd0,
        ST_WAIT_CLOCKS = 2'd1,
        ST_INIT        = 2'd2,
        ST_RUN         = 2'd3
    } seq_state_e;

    typedef enum logic {
        SIDE_ADC = 1'b0,
        SIDE_DAC = 1'b1
    } conv_side_e;

    localparam int unsigned ADC_INIT_FRAMES = 522;
    localparam int unsigned DAC_INIT_FRAMES = 516;

    function automatic int unsigned init_frames(conv_side_e side);
        return (side == SIDE_ADC) ? ADC_INIT_FRAMES : DAC_INIT_FRAMES;
    endfunction

endpackage

// File: rtl/cps_sync_edge.sv
module cps_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o,
    output logic toggle_o
);
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign level_o  = chain_q[STAGES-1];
    assign rise_o   = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign toggle_o = chain_q[STAGES-1] ^ chain_q[STAGES];
endmodule

// File: rtl/cps_clk_monitor.sv
module cps_clk_monitor #(
    parameter int unsigned TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    output logic present_o
);
    localparam int unsigned CW = $clog2(TIMEOUT + 1);

    logic [CW-1:0] idle_d, idle_q;

    always_comb begin
        idle_d = idle_q;
        if (edge_i)                   idle_d = '0;
        else if (idle_q < CW'(TIMEOUT)) idle_d = idle_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idle_q <= CW'(TIMEOUT);
        else        idle_q <= idle_d;
    end

    assign present_o = (idle_q < CW'(TIMEOUT));

    assert_edge_restores_R6: assert property (@(posedge clk) disable iff (!rst_n)
        edge_i |=> present_o);

    assert_idle_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        idle_q <= CW'(TIMEOUT));
endmodule

// File: rtl/codec_pwrup_seq.sv
module codec_pwrup_seq
    import codec_pwrup_pkg::*;
#(
    parameter conv_side_e  SIDE           = SIDE_ADC,
    parameter int unsigned MCLK_TIMEOUT   = 64,
    parameter int unsigned SYNC_STAGES    = 2,
    parameter bit          PWR_EN_DEFAULT = 1'b1
) (
    input  logic clk,
    input  logic pdn_n,
    input  logic mclk_i,
    input  logic lrck_i,
    input  logic pwr_wr_i,
    input  logic pwr_wdata_i,
    input  logic sdti_i,
    output logic sdto_o,
    output logic ready_o,
    output logic filt_rst_o
);
    localparam int unsigned INIT_FRAMES = init_frames(SIDE);
    localparam int unsigned CW          = $clog2(INIT_FRAMES + 1);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
        logic          pwr_en;
        logic          filt_rst;
    } seq_regs_t;

    logic mclk_level, mclk_rise, mclk_toggle, mclk_ok;
    logic lrck_level, frame_rise, lrck_toggle;

    cps_sync_edge #(.STAGES(SYNC_STAGES)) u_mclk_sync (
        .clk(clk), .rst_n(pdn_n), .async_i(mclk_i),
        .level_o(mclk_level), .rise_o(mclk_rise), .toggle_o(mclk_toggle)
    );

    cps_sync_edge #(.STAGES(SYNC_STAGES)) u_lrck_sync (
        .clk(clk), .rst_n(pdn_n), .async_i(lrck_i),
        .level_o(lrck_level), .rise_o(frame_rise), .toggle_o(lrck_toggle)
    );

    cps_clk_monitor #(.TIMEOUT(MCLK_TIMEOUT)) u_mclk_mon (
        .clk(clk), .rst_n(pdn_n), .edge_i(mclk_toggle), .present_o(mclk_ok)
    );

    seq_regs_t regs_d, regs_q;
    logic      start_ok;

    always_comb begin
        regs_d          = regs_q;
        regs_d.filt_rst = 1'b0;
        if (pwr_wr_i) regs_d.pwr_en = pwr_wdata_i;
        start_ok = regs_q.pwr_en && mclk_ok && frame_rise;

        unique case (regs_q.st)
            ST_POWER_DOWN: begin
                regs_d.st = ST_WAIT_CLOCKS;
            end
            ST_WAIT_CLOCKS: begin
                if (start_ok) begin
                    regs_d.st       = ST_INIT;
                    regs_d.cnt      = '0;
                    regs_d.filt_rst = 1'b1;
                end
            end
            ST_INIT: begin
                if (!mclk_ok) begin
                    regs_d.st = ST_POWER_DOWN;
                end else if (!regs_q.pwr_en) begin
                    regs_d.st = ST_WAIT_CLOCKS;
                end else if (frame_rise) begin
                    if (regs_q.cnt == CW'(INIT_FRAMES - 1)) regs_d.st = ST_RUN;
                    else                                   regs_d.cnt = regs_q.cnt + 1'b1;
                end
            end
            ST_RUN: begin
                if (!mclk_ok)            regs_d.st = ST_POWER_DOWN;
                else if (!regs_q.pwr_en) regs_d.st = ST_WAIT_CLOCKS;
            end
            default: regs_d.st = ST_POWER_DOWN;
        endcase
    end

    always_ff @(posedge clk or negedge pdn_n) begin
        if (!pdn_n) begin
            regs_q.st       <= ST_POWER_DOWN;
            regs_q.cnt      <= '0;
            regs_q.pwr_en   <= PWR_EN_DEFAULT;
            regs_q.filt_rst <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ready_o    = (regs_q.st == ST_RUN);
    assign sdto_o     = ready_o & sdti_i;
    assign filt_rst_o = regs_q.filt_rst;

    assert_sdto_gated_R2: assert property (@(posedge clk) disable iff (!pdn_n)
        !ready_o |-> !sdto_o);

    assert_start_needs_clocks_R3: assert property (@(posedge clk) disable iff (!pdn_n)
        (regs_q.st == ST_WAIT_CLOCKS && !(mclk_ok && frame_rise && regs_q.pwr_en))
        |=> regs_q.st != ST_INIT);

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!pdn_n)
        (regs_q.st == ST_INIT) |-> (regs_q.cnt < CW'(INIT_FRAMES)));

    assert_run_on_frame_R4: assert property (@(posedge clk) disable iff (!pdn_n)
        (regs_q.st == ST_INIT && !frame_rise) |=> regs_q.st != ST_RUN);

    assert_filt_single_R5: assert property (@(posedge clk) disable iff (!pdn_n)
        filt_rst_o |=> !filt_rst_o);

    assert_clock_loss_R6: assert property (@(posedge clk) disable iff (!pdn_n)
        ((regs_q.st == ST_INIT || regs_q.st == ST_RUN) && !mclk_ok)
        |=> regs_q.st == ST_POWER_DOWN);

    assert_pwr_off_R7: assert property (@(posedge clk) disable iff (!pdn_n)
        ((regs_q.st == ST_INIT || regs_q.st == ST_RUN) && mclk_ok && !regs_q.pwr_en)
        |=> regs_q.st == ST_WAIT_CLOCKS);
endmodule

// File: tb/test_codec_pwrup_seq.sv
module test_codec_pwrup_seq;
    localparam int unsigned N_INIT = 522;

    logic clk = 1'b0;
    logic pdn_n = 1'b0;
    logic mclk = 1'b0, lrck = 1'b0;
    logic pwr_wr = 1'b0, pwr_wdata = 1'b0, sdti = 1'b1;
    logic sdto, ready, filt_rst;
    logic mclk_run = 1'b0;
    int   checks = 0, errors = 0, filt_cnt = 0;

    always #2.5 clk = ~clk;

    codec_pwrup_seq i_codec_pwrup_seq (
        .clk(clk), .pdn_n(pdn_n), .mclk_i(mclk), .lrck_i(lrck),
        .pwr_wr_i(pwr_wr), .pwr_wdata_i(pwr_wdata), .sdti_i(sdti),
        .sdto_o(sdto), .ready_o(ready), .filt_rst_o(filt_rst)
    );

    initial forever begin
        @(negedge clk);
        if (mclk_run) mclk = ~mclk;
    end

    always @(negedge clk) if (filt_rst) filt_cnt++;

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frames(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); lrck = 1'b1;
            idle(6);        lrck = 1'b0;
            idle(6);
        end
    endtask

    task automatic write_pwr(logic v);
        @(negedge clk); pwr_wr = 1'b1; pwr_wdata = v;
        @(negedge clk); pwr_wr = 1'b0;
        idle(3);
    endtask

    task automatic full_init(string req, int filt_exp);
        frames(1);
        chk({req, " filter pulse at start (R5)"}, filt_cnt, filt_exp);
        frames(N_INIT - 1);
        chk({req, " not ready one frame early (R4)"}, ready, 0);
        chk({req, " output zero during init (R4)"}, sdto, 0);
        frames(1);
        chk({req, " ready after full count (R4)"}, ready, 1);
        chk({req, " single filter pulse (R5)"}, filt_cnt, filt_exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        idle(5);
        chk("R1 ready in power-down", ready, 0);
        chk("R1 sdto in power-down", sdto, 0);
        chk("R1 filt_rst in power-down", filt_rst, 0);
        pdn_n = 1'b1;
        idle(4);
        frames(4);
        chk("R3 no start without master clock", filt_cnt, 0);
        chk("R3 not ready without master clock", ready, 0);

        mclk_run = 1'b1;
        idle(10);
        full_init("R4 first init", 1);
        sdti = 1'b1; idle(1);
        chk("R2 pass-through high", sdto, 1);
        sdti = 1'b0; idle(1);
        chk("R2 pass-through low", sdto, 0);
        sdti = 1'b1;

        write_pwr(1'b0);
        chk("R7 ready drops on power bit clear", ready, 0);
        chk("R7 sdto low on power bit clear", sdto, 0);
        frames(3);
        chk("R7 no restart while bit clear", filt_cnt, 1);
        chk("R7 still not ready", ready, 0);

        write_pwr(1'b1);
        frames(1);
        chk("R8 init starts after set", filt_cnt, 2);
        frames(100);
        write_pwr(1'b0);
        write_pwr(1'b1);
        full_init("R8 restarted init", 3);

        mclk_run = 1'b0;
        idle(80);
        chk("R6 ready drops on clock loss", ready, 0);
        chk("R6 sdto low on clock loss", sdto, 0);
        frames(2);
        chk("R6 no start while clock lost", filt_cnt, 3);
        mclk_run = 1'b1;
        idle(10);
        full_init("R6 recovery init", 4);

        write_pwr(1'b0);
        @(negedge clk); pdn_n = 1'b0;
        idle(3);
        chk("R1 ready low in power-down pulse", ready, 0);
        pdn_n = 1'b1;
        idle(10);
        full_init("R1 default restored", 5);

        summary();
    end
endmodule